// File: doc/BRIEF.md
# Banked GPIO Controller with Sticky Edge Capture

This block controls a parameterised number of general-purpose pins (64 or 96) through a plain 32-bit word-addressed register bus. Every pin has a synchronised level readback and a direction bit. Its output latch is driven high or low by writing ones to separate set and clear ports. Rising and falling edges can each be enabled on their own. A detected edge is held in a sticky status bit until software acknowledges it by writing a one to that bit. Each pin also has a 2-bit alternate-function code, which is exported to the pad multiplexer.

Registers come in banks of NPIN/32 consecutive words, and the banks are stacked in a fixed type order. Every offset therefore scales with the pin count. Software reaches a pin by taking its bank from the register type and then picking the word with pin/32 and the bit with pin%32. A single interrupt line stays high while any status bit is set.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: With NREG = NPIN/32, the word for register type t and bank word w sits at byte address (t*NREG + w)*4, and pin p uses word p/32, bit p%32. The type indices are: 0 level, 1 direction, 2 set, 3 clear, 4 rising-enable, 5 falling-enable, 6 edge-status, 7 alternate-function.
- R2: Reading a level word returns pad_in after a two-flop synchroniser. A pad change made before clock edge k is readable after edge k+1 and not after edge k.
- R3: Direction bits are read/write. A 1 drives the pin's pad_oe high (output) and a 0 makes the pin an input.
- R4: Writing a 1 to a set-port bit drives that pin's pad_out high. Writing a 1 to a clear-port bit drives it low. Zero bits leave the latch unchanged. Reads of the set and clear words return 0.
- R5: The rising-enable and falling-enable bits act independently. With both set, a pin captures either edge.
- R6: A qualifying edge sets the pin's status bit, which becomes visible after the third clock edge following the pad change. The bit stays set until a 1 is written to it. Zero bits in a status write have no effect.
- R7: If an edge is detected in the same cycle as a status-clear write to that bit, the bit remains set.
- R8: irq is high exactly while at least one status bit is set.
- R9: The alternate-function region starts at word 7*NREG and spans 2*NREG words. Word a holds pins 16a..16a+15, with pin p's 2-bit code at bit position (p%16)*2. Codes are read/write and appear on alt_sel[2p+1:2p]. Code 0 means plain GPIO.
- R10: Reads of unmapped words return 0. Writes to the level words are ignored. Any access whose byte address has nonzero low two bits reads 0 and writes nothing.
- R11: After reset all pins are inputs, pad_out is low, the edge enables and status bits are clear, alt_sel is 0, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Write strobe for the addressed word |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NPIN | Asynchronous pad inputs |
| pad_out | output | NPIN | Output latch values |
| pad_oe | output | NPIN | Output enables (direction bits) |
| alt_sel | output | 2*NPIN | Alternate-function codes, two bits per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
The bench uses the 64-pin configuration.

The set port is tried with a walking single-bit pattern across both bank words, which separates the word selection from the bit selection. The clear port is tried with alternating masks, which show that zero bits leave the latch alone.

The edge logic is driven with:
- whole-word rising steps into a bank with only rising enabled, and falling steps into a bank with only falling enabled, which tell the two enables apart;
- a single pin with both enables set and toggled in both directions;
- an edge placed in the exact cycle of its acknowledge write.

Partial acknowledges and zero-valued acknowledges separate a correct sticky clear from a whole-word clear. The alternate-function codes are computed from the pin number, which exposes any error in the field offset or the word offset.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    RT_LEVEL = 3'd0,
    RT_DIR   = 3'd1,
    RT_SET   = 3'd2,
    RT_CLR   = 3'd3,
    RT_RISE  = 3'd4,
    RT_FALL  = 3'd5,
    RT_STAT  = 3'd6,
    RT_ALT   = 3'd7
  } reg_type_e;

  // word index of register type t, bank word w
  function automatic int unsigned word_index(int unsigned t, int unsigned w, int unsigned nreg);
    return t * nreg + w;
  endfunction

  // bit offset of a pin's function code inside its alternate word
  function automatic int unsigned alt_shift(int unsigned pin);
    return (pin % 16) * 2;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPIN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] lvl,
  output logic [NPIN-1:0] rise,
  output logic [NPIN-1:0] fall
);

  logic [NPIN-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;

  // R5: a rising pulse marks a level that was low one cycle earlier
  p_rise_was_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |-> ((rise & $past(lvl)) == '0));

  // R5: a falling pulse marks a level that was high one cycle earlier
  p_fall_was_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall) |-> ((fall & ~$past(lvl)) == '0));

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int NPIN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] rise,
  input  logic [NPIN-1:0] fall,
  input  logic [NPIN-1:0] rise_en,
  input  logic [NPIN-1:0] fall_en,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] sts,
  output logic            irq
);

  logic [NPIN-1:0] evt;
  logic [NPIN-1:0] sts_q;

  assign evt = (rise & rise_en) | (fall & fall_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_mask) | evt;
  end

  assign sts = sts_q;
  assign irq = |sts_q;

  // R6: set bits that are not acknowledged stay set
  p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_q & ~clr_mask)) |=> ((sts_q & $past(sts_q & ~clr_mask)) == $past(sts_q & ~clr_mask)));

  // R7: every qualified edge lands, even against a clear
  p_edge_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((sts_q & $past(evt)) == $past(evt)));

  // R8: the interrupt can only rise after an edge
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|evt));

  // R8: the interrupt can only fall after an acknowledge
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(|clr_mask));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NPIN = 64,
  parameter int AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [2*NPIN-1:0] alt_sel,
  output logic              irq
);

  localparam int NREG = NPIN / 32;
  localparam int NALT = 2 * NREG;
  localparam int WW   = AW - 2;
  localparam logic [WW-1:0] ALT_LO = WW'(word_index(7, 0, NREG));
  localparam logic [WW-1:0] ALT_HI = WW'(word_index(7, NALT, NREG));
  localparam logic [WW-1:0] TY_LEVEL = WW'(RT_LEVEL);
  localparam logic [WW-1:0] TY_DIR   = WW'(RT_DIR);
  localparam logic [WW-1:0] TY_SET   = WW'(RT_SET);
  localparam logic [WW-1:0] TY_CLR   = WW'(RT_CLR);
  localparam logic [WW-1:0] TY_RISE  = WW'(RT_RISE);
  localparam logic [WW-1:0] TY_FALL  = WW'(RT_FALL);
  localparam logic [WW-1:0] TY_STAT  = WW'(RT_STAT);

  // address decode
  logic [WW-1:0] widx, typ_w, bank_w, alt_w;
  logic          aligned, wr_ok, alt_hit;

  assign widx    = bus_addr[AW-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wen && aligned;
  assign typ_w   = widx / WW'(NREG);
  assign bank_w  = widx % WW'(NREG);
  assign alt_hit = (widx >= ALT_LO) && (widx < ALT_HI);
  assign alt_w   = widx - ALT_LO;

  logic [NPIN-1:0]   bank_m, wd_rep;
  logic [2*NPIN-1:0] alt_m, alt_rep;

  for (genvar b = 0; b < NREG; b++) begin : g_bank
    assign bank_m[32*b +: 32] = {32{bank_w == WW'(b)}};
    assign wd_rep[32*b +: 32] = bus_wdata;
  end
  for (genvar a = 0; a < NALT; a++) begin : g_alt
    assign alt_m[32*a +: 32]   = {32{alt_hit && (alt_w == WW'(a))}};
    assign alt_rep[32*a +: 32] = bus_wdata;
  end

  // write-one strobes
  logic [NPIN-1:0] set_m, clr_m, ack_m;
  assign set_m = (wr_ok && !alt_hit && typ_w == TY_SET)  ? (wd_rep & bank_m) : '0;
  assign clr_m = (wr_ok && !alt_hit && typ_w == TY_CLR)  ? (wd_rep & bank_m) : '0;
  assign ack_m = (wr_ok && !alt_hit && typ_w == TY_STAT) ? (wd_rep & bank_m) : '0;

  // control registers
  logic [NPIN-1:0]   dir_q, out_q, ren_q, fen_q;
  logic [2*NPIN-1:0] alt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      alt_q <= '0;
    end else begin
      out_q <= (out_q | set_m) & ~clr_m;
      if (wr_ok && !alt_hit && typ_w == TY_DIR)
        dir_q <= (dir_q & ~bank_m) | (wd_rep & bank_m);
      if (wr_ok && !alt_hit && typ_w == TY_RISE)
        ren_q <= (ren_q & ~bank_m) | (wd_rep & bank_m);
      if (wr_ok && !alt_hit && typ_w == TY_FALL)
        fen_q <= (fen_q & ~bank_m) | (wd_rep & bank_m);
      if (wr_ok)
        alt_q <= (alt_q & ~alt_m) | (alt_rep & alt_m);
    end
  end

  // input path and edge capture
  logic [NPIN-1:0] lvl, rise, fall, sts;

  gpio_in_sync #(.NPIN(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pad_in(pad_in),
    .lvl   (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  gpio_edge_status #(.NPIN(NPIN)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise),
    .fall    (fall),
    .rise_en (ren_q),
    .fall_en (fen_q),
    .clr_mask(ack_m),
    .sts     (sts),
    .irq     (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (alt_hit) begin
        for (int a = 0; a < NALT; a++)
          if (alt_w == WW'(a)) bus_rdata = alt_q[32*a +: 32];
      end else begin
        for (int b = 0; b < NREG; b++) begin
          if (bank_w == WW'(b)) begin
            case (typ_w)
              TY_LEVEL: bus_rdata = lvl[32*b +: 32];
              TY_DIR:   bus_rdata = dir_q[32*b +: 32];
              TY_RISE:  bus_rdata = ren_q[32*b +: 32];
              TY_FALL:  bus_rdata = fen_q[32*b +: 32];
              TY_STAT:  bus_rdata = sts[32*b +: 32];
              default:  bus_rdata = '0;
            endcase
          end
        end
      end
    end
  end

  assign pad_out = out_q;
  assign pad_oe  = dir_q;
  assign alt_sel = alt_q;

  // R4: set-port ones reach the latch
  p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_m) |=> ((pad_out & $past(set_m)) == $past(set_m)));

  // R4: clear-port ones reach the latch
  p_clr_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_m) |=> ((pad_out & $past(clr_m)) == '0));

  // R4: bits not named by a set or clear write keep their value
  p_latch_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pad_out ^ $past(pad_out)) & ~$past(set_m | clr_m)) == '0));

  // R9: an alternate-function write replaces exactly its word
  p_alt_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|alt_m && wr_ok) |=> ((alt_sel & $past(alt_m)) == $past(alt_rep & alt_m)));

  // R3: direction holds while nothing writes it
  p_dir_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wen |=> $stable(pad_oe));

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb;

  localparam int NPIN = 64;
  localparam int NREG = 2;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         bus_wen = 0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [63:0]  pad_in = '0;
  logic [63:0]  pad_out, pad_oe;
  logic [127:0] alt_sel;
  logic         irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctrl #(.NPIN(NPIN), .AW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel), .irq(irq)
  );

  function automatic int adr(int t, int w);
    return (t * NREG + w) * 4;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wen = 1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_wen = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 8'(a);
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  logic [31:0]  r;
  logic [63:0]  out_m;
  logic [127:0] alt_exp;

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: reset state, every mapped and some unmapped words
    chk("R11 pad_oe", pad_oe, 64'h0);
    chk("R11 pad_out", pad_out, 64'h0);
    chk("R11 alt_sel", alt_sel[63:0] | alt_sel[127:64], 64'h0);
    chk("R11 irq", 64'(irq), 64'h0);
    for (int w = 0; w < 18; w++) begin
      rd(w * 4, r);
      chk("R11 word read", 64'(r), 64'h0);
    end

    // R1 R4: walking set across both bank words
    out_m = '0;
    for (int p = 0; p < NPIN; p++) begin
      wr(adr(2, p / 32), 32'h1 << (p % 32));
      out_m[p] = 1'b1;
      chk("R1 R4 set walk", pad_out, out_m);
    end
    wr(adr(3, 0), 32'h5555_5555);
    wr(adr(3, 1), 32'hAAAA_AAAA);
    out_m = 64'h5555_5555_AAAA_AAAA;
    chk("R4 clear mask", pad_out, out_m);
    wr(adr(2, 0), 32'h0);
    wr(adr(3, 1), 32'h0);
    chk("R4 zero writes keep latch", pad_out, out_m);
    rd(adr(2, 0), r); chk("R4 set reads zero", 64'(r), 64'h0);
    rd(adr(3, 1), r); chk("R4 clear reads zero", 64'(r), 64'h0);

    // R3: direction
    wr(adr(1, 0), 32'hA5A5_F00F);
    wr(adr(1, 1), 32'h0F0F_1234);
    chk("R3 pad_oe", pad_oe, 64'h0F0F_1234_A5A5_F00F);
    rd(adr(1, 1), r); chk("R3 dir readback", 64'(r), 64'h0F0F_1234);
    // R10: misaligned write ignored
    wr(adr(1, 0) + 1, 32'h0);
    chk("R10 misaligned write", pad_oe, 64'h0F0F_1234_A5A5_F00F);
    rd(adr(1, 0) + 2, r); chk("R10 misaligned read", 64'(r), 64'h0);

    // R2: synchroniser latency
    @(negedge clk);
    bus_addr = 8'(adr(0, 0));
    pad_in = 64'h1357_9BDF_C0DE_BEEF;
    @(negedge clk); #1 chk("R2 level after one edge", 64'(bus_rdata), 64'h0);
    @(negedge clk); #1 chk("R2 level after two edges", 64'(bus_rdata), 64'hC0DE_BEEF);
    rd(adr(0, 1), r); chk("R2 level upper word", 64'(r), 64'h1357_9BDF);
    // R10: level words are not writable; unmapped reads are zero
    wr(adr(0, 1), 32'h0);
    rd(adr(0, 1), r); chk("R10 level write ignored", 64'(r), 64'h1357_9BDF);
    for (int w = 18; w < 64; w++) begin
      rd(w * 4, r);
      chk("R10 unmapped read", 64'(r), 64'h0);
    end

    // R5 R6 R8: edge enables and sticky status
    pad_in = '0;
    wr(adr(4, 0), 32'hFFFF_FFFF);
    wr(adr(5, 1), 32'hFFFF_FFFF);
    settle();
    wr(adr(6, 0), 32'hFFFF_FFFF);
    wr(adr(6, 1), 32'hFFFF_FFFF);
    chk("R8 irq low before edges", 64'(irq), 64'h0);
    @(negedge clk) pad_in = '1;
    @(negedge clk); @(negedge clk);
    chk("R6 status not yet after two edges", 64'(irq), 64'h0);
    @(negedge clk);
    chk("R6 R8 irq after third edge", 64'(irq), 64'h1);
    rd(adr(6, 0), r); chk("R5 rising bank captured", 64'(r), 64'hFFFF_FFFF);
    rd(adr(6, 1), r); chk("R5 falling-only bank idle on rise", 64'(r), 64'h0);
    wr(adr(6, 0), 32'hFFFF_0000);
    rd(adr(6, 0), r); chk("R6 partial acknowledge", 64'(r), 64'h0000_FFFF);
    wr(adr(6, 0), 32'h0);
    rd(adr(6, 0), r); chk("R6 zero acknowledge", 64'(r), 64'h0000_FFFF);
    chk("R8 irq held", 64'(irq), 64'h1);
    wr(adr(6, 0), 32'h0000_FFFF);
    chk("R8 irq cleared", 64'(irq), 64'h0);
    @(negedge clk) pad_in = '0;
    settle();
    rd(adr(6, 0), r); chk("R5 rising-only bank idle on fall", 64'(r), 64'h0);
    rd(adr(6, 1), r); chk("R5 falling bank captured", 64'(r), 64'hFFFF_FFFF);
    wr(adr(6, 1), 32'hFFFF_FFFF);

    // R5: both enables on pin 35
    wr(adr(4, 1), 32'h8);
    wr(adr(5, 1), 32'h8);
    @(negedge clk) pad_in[35] = 1'b1;
    settle();
    rd(adr(6, 1), r); chk("R5 both-edge pin rise", 64'(r), 64'h8);
    wr(adr(6, 1), 32'h8);
    @(negedge clk) pad_in[35] = 1'b0;
    settle();
    rd(adr(6, 1), r); chk("R5 both-edge pin fall", 64'(r), 64'h8);
    wr(adr(6, 1), 32'h8);
    rd(adr(6, 1), r); chk("R6 acknowledged", 64'(r), 64'h0);

    // R7: edge in the acknowledge cycle on pin 5
    @(negedge clk) pad_in[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_wen = 1; bus_addr = 8'(adr(6, 0)); bus_wdata = 32'h20;
    @(negedge clk);
    bus_wen = 0;
    #1 chk("R7 edge survives clear", 64'(bus_rdata), 64'h20);
    chk("R7 irq", 64'(irq), 64'h1);
    wr(adr(6, 0), 32'h20);
    rd(adr(6, 0), r); chk("R7 later clear works", 64'(r), 64'h0);

    // R9: alternate-function codes derived from pin number
    alt_exp = '0;
    for (int p = 0; p < NPIN; p++)
      alt_exp[2*p +: 2] = 2'((p * 7 + 1) % 4);
    for (int a = 0; a < 4; a++)
      wr((7 * NREG + a) * 4, alt_exp[32*a +: 32]);
    chk("R9 alt_sel low", alt_sel[63:0], alt_exp[63:0]);
    chk("R9 alt_sel high", alt_sel[127:64], alt_exp[127:64]);
    for (int a = 0; a < 4; a++) begin
      rd((7 * NREG + a) * 4, r);
      chk("R9 alt readback", 64'(r), 64'(alt_exp[32*a +: 32]));
    end
    for (int p = 0; p < NPIN; p += 9) begin
      rd((7 * NREG + p / 16) * 4, r);
      chk("R9 field position", 64'((r >> ((p % 16) * 2)) & 32'h3), 64'((p * 7 + 1) % 4));
    end
    chk("R4 latch untouched by other writes", pad_out, out_m);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule